// File: doc/BRIEF.md
# Peripheral Data Port Bridge

This block lets an 8-bit processor reach an external peripheral data bus through a single bidirectional port, without separate buffers or decoders. The port stays released unless three things hold together: software has set the peripheral mode bit, an address decoder has pulled one of two active-low select lines low, and exactly one of the active-low read or write strobes is asserted. A write strobe sends processor data out to the peripheral. A read strobe returns peripheral data to the processor bus.

The block also drives the peripheral address lines from a latched copy of the processor address. Each address line has its own direction bit. Clearing a bit releases that line, so software can hand the address bus to an external DMA master. The mode and direction registers sit behind a small synchronous configuration interface that reads back with no wait states. Every bidirectional line is split into separate output, output-enable and input signals.

Top module: `periph_port_bridge`

## Requirements
- R1: After reset the mode bit and all direction bits are 0. All of per_d_oe, cpu_d_oe and per_a_oe are 0, and config offsets 0, 1 and 2 read 0.
- R2: When the mode bit is 1, at least one psel_n bit is low, wr_n is low and rd_n is high, per_d_oe is 1 and per_d_o equals cpu_d_i in the same cycle.
- R3: When the mode bit is 1, at least one psel_n bit is low, rd_n is low and wr_n is high, cpu_d_oe is 1 and cpu_d_o equals per_d_i in the same cycle.
- R4: When both psel_n bits are high, per_d_oe and cpu_d_oe are 0. Either select alone, or both together, is enough to enable the port.
- R5: When the mode bit (offset 0, bit 0) is 0, per_d_oe and cpu_d_oe stay 0 whatever the selects and strobes do.
- R6: When rd_n and wr_n are low together, neither per_d_oe nor cpu_d_oe is 1.
- R7: per_d_oe and cpu_d_oe are never 1 in the same cycle.
- R8: per_a_oe[i] equals direction bit i. Offset 1 holds direction bits 7:0 and offset 2 holds bits 15:8. A line whose bit is 1 drives per_a_o[i] from the latched address.
- R9: A direction write becomes visible on per_a_oe at the clock edge that samples cfg_we, and not before. Direction bits not written keep their value.
- R10: When addr_le is high at a clock edge, cpu_addr is latched. The latched value holds while addr_le is low.
- R11: cfg_rdata shows the register at cfg_addr in the same cycle. Offset 0 returns the mode bit in bit 0 with the other bits 0, and a mode write stores only wdata bit 0. Offset 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| addr_le | input | 1 | Address latch enable |
| cpu_d_i | input | 8 | Processor data toward the peripheral |
| cpu_d_o | output | 8 | Peripheral data toward the processor |
| cpu_d_oe | output | 1 | Processor data bus drive enable |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| psel_n | input | 2 | Decoder peripheral selects, active low |
| per_d_i | input | 8 | Peripheral data bus input |
| per_d_o | output | 8 | Peripheral data bus output |
| per_d_oe | output | 1 | Peripheral data bus drive enable |
| per_a_o | output | 16 | Peripheral address lines |
| per_a_oe | output | 16 | Per-line address drive enables |
| cfg_addr | input | 2 | Config register offset |
| cfg_we | input | 1 | Config write enable |
| cfg_wdata | input | 8 | Config write data |
| cfg_rdata | output | 8 | Config read data |

## Verification
Two functions can fall in the same cycle. A configuration write can land in the cycle of a live peripheral transfer: the mode bit is cleared, or a direction byte is changed, while a select and a strobe are active. The bench provokes both cases on purpose, and also lets random traffic overlap them. The judgement is the cycle boundary: during the write cycle the port must still behave under the old register value, and from the next cycle on it must follow the new one. A behavioural model in the bench tracks the registers and the latched address and is compared against every output on every clock.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
   localparam int unsigned REG_MODE = 0;
   localparam int unsigned DIR_BASE = 1;

   typedef enum logic [1:0] {
      XFER_IDLE,
      XFER_TO_PERIPH,
      XFER_FROM_PERIPH,
      XFER_CLASH
   } xfer_e;

   function automatic xfer_e classify(input logic rd_n, input logic wr_n);
      case ({rd_n, wr_n})
         2'b10:   return XFER_TO_PERIPH;
         2'b01:   return XFER_FROM_PERIPH;
         2'b00:   return XFER_CLASH;
         default: return XFER_IDLE;
      endcase
   endfunction
endpackage

// File: rtl/pdb_regs.sv
module pdb_regs #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int REG_AW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              mode_en,
   output logic [ADDR_W-1:0] dir
);
   localparam int DIR_BYTES = ADDR_W / DATA_W;

   logic              mode_q;
   logic [ADDR_W-1:0] dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= 1'b0;
      else if (cfg_we && cfg_addr == REG_AW'(pdb_pkg::REG_MODE))
         mode_q <= cfg_wdata[0];
   end

   for (genvar g = 0; g < DIR_BYTES; g++) begin : g_dir
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dir_q[g*DATA_W +: DATA_W] <= '0;
         else if (cfg_we && cfg_addr == REG_AW'(pdb_pkg::DIR_BASE + g))
            dir_q[g*DATA_W +: DATA_W] <= cfg_wdata;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == REG_AW'(pdb_pkg::REG_MODE))
         cfg_rdata[0] = mode_q;
      for (int b = 0; b < DIR_BYTES; b++)
         if (cfg_addr == REG_AW'(pdb_pkg::DIR_BASE + b))
            cfg_rdata = dir_q[b*DATA_W +: DATA_W];
   end

   assign mode_en = mode_q;
   assign dir     = dir_q;

   AST_DIR_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == REG_AW'(pdb_pkg::DIR_BASE)) |=> (dir[DATA_W-1:0] == $past(cfg_wdata))); // R9
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(dir)); // R9
endmodule

// File: rtl/pdb_dataport.sv
module pdb_dataport #(
   parameter int DATA_W = 8,
   parameter int NSEL   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_en,
   input  logic [NSEL-1:0]   psel_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] cpu_d_i,
   input  logic [DATA_W-1:0] per_d_i,
   output logic [DATA_W-1:0] cpu_d_o,
   output logic              cpu_d_oe,
   output logic [DATA_W-1:0] per_d_o,
   output logic              per_d_oe
);
   import pdb_pkg::*;

   xfer_e kind;
   logic  sel_hit;
   logic  gate;

   assign kind     = classify(rd_n, wr_n);
   assign sel_hit  = ~&psel_n;
   assign gate     = mode_en & sel_hit;
   assign per_d_oe = gate && (kind == XFER_TO_PERIPH);
   assign cpu_d_oe = gate && (kind == XFER_FROM_PERIPH);
   assign per_d_o  = per_d_oe ? cpu_d_i : '0;
   assign cpu_d_o  = cpu_d_oe ? per_d_i : '0;

   AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(per_d_oe && cpu_d_oe)); // R7
   AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |-> (!per_d_oe && !cpu_d_oe)); // R5
   AST_NO_SELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&psel_n) |-> (!per_d_oe && !cpu_d_oe)); // R4
   AST_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !wr_n) |-> (!per_d_oe && !cpu_d_oe)); // R6
endmodule

// File: rtl/pdb_addrport.sv
module pdb_addrport #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_le,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [ADDR_W-1:0] dir,
   output logic [ADDR_W-1:0] per_a_o,
   output logic [ADDR_W-1:0] per_a_oe
);
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (addr_le)
         addr_q <= cpu_addr;
   end

   assign per_a_o  = addr_q & dir;
   assign per_a_oe = dir;

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_le |=> $stable(addr_q)); // R10
   AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      addr_le |=> (addr_q == $past(cpu_addr))); // R10
endmodule

// File: rtl/periph_port_bridge.sv
module periph_port_bridge #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int NSEL   = 2,
   parameter int REG_AW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              addr_le,
   input  logic [DATA_W-1:0] cpu_d_i,
   output logic [DATA_W-1:0] cpu_d_o,
   output logic              cpu_d_oe,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [NSEL-1:0]   psel_n,
   input  logic [DATA_W-1:0] per_d_i,
   output logic [DATA_W-1:0] per_d_o,
   output logic              per_d_oe,
   output logic [ADDR_W-1:0] per_a_o,
   output logic [ADDR_W-1:0] per_a_oe,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata
);
   localparam int DIR_BYTES = ADDR_W / DATA_W;

   if (ADDR_W % DATA_W != 0) begin : g_bad_width
      $error("ADDR_W must be a whole number of DATA_W bytes");
   end
   if (DIR_BYTES + 1 > (1 << REG_AW)) begin : g_bad_regspace
      $error("REG_AW too small for mode and direction registers");
   end
   if (NSEL < 1) begin : g_bad_nsel
      $error("NSEL must be at least 1");
   end

   logic              mode_en;
   logic [ADDR_W-1:0] dir;

   pdb_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mode_en(mode_en), .dir(dir)
   );

   pdb_dataport #(.DATA_W(DATA_W), .NSEL(NSEL)) u_data (
      .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .psel_n(psel_n),
      .rd_n(rd_n), .wr_n(wr_n), .cpu_d_i(cpu_d_i), .per_d_i(per_d_i),
      .cpu_d_o(cpu_d_o), .cpu_d_oe(cpu_d_oe), .per_d_o(per_d_o), .per_d_oe(per_d_oe)
   );

   pdb_addrport #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .addr_le(addr_le), .cpu_addr(cpu_addr),
      .dir(dir), .per_a_o(per_a_o), .per_a_oe(per_a_oe)
   );
endmodule

// File: tb/periph_port_bridge_test.sv
module periph_port_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        addr_le = 1'b0;
   logic [7:0]  cpu_d_i = '0;
   logic [7:0]  cpu_d_o;
   logic        cpu_d_oe;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [1:0]  psel_n = 2'b11;
   logic [7:0]  per_d_i = '0;
   logic [7:0]  per_d_o;
   logic        per_d_oe;
   logic [15:0] per_a_o;
   logic [15:0] per_a_oe;
   logic [1:0]  cfg_addr = '0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // behavioural reference state
   bit          m_mode;
   logic [15:0] m_dir;
   logic [15:0] m_addr;

   always #10 clk = ~clk;

   periph_port_bridge uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .addr_le(addr_le),
      .cpu_d_i(cpu_d_i), .cpu_d_o(cpu_d_o), .cpu_d_oe(cpu_d_oe),
      .rd_n(rd_n), .wr_n(wr_n), .psel_n(psel_n), .per_d_i(per_d_i),
      .per_d_o(per_d_o), .per_d_oe(per_d_oe), .per_a_o(per_a_o), .per_a_oe(per_a_oe),
      .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode <= 0; m_dir <= '0; m_addr <= '0;
      end else begin
         if (cfg_we) begin
            if (cfg_addr == 2'd0) m_mode <= cfg_wdata[0];
            else if (cfg_addr == 2'd1) m_dir[7:0] <= cfg_wdata;
            else if (cfg_addr == 2'd2) m_dir[15:8] <= cfg_wdata;
         end
         if (addr_le) m_addr <= cpu_addr;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit any_sel = (psel_n[0] == 1'b0) || (psel_n[1] == 1'b0);
      bit e_out = 0;
      bit e_in = 0;
      logic [7:0] e_rd;
      if (m_mode && any_sel) begin
         if (!wr_n && rd_n) e_out = 1;
         if (!rd_n && wr_n) e_in = 1;
      end
      chk("R2", per_d_oe, e_out);
      if (e_out) chk("R2", per_d_o, cpu_d_i);
      chk("R3", cpu_d_oe, e_in);
      if (e_in) chk("R3", cpu_d_o, per_d_i);
      chk("R8", per_a_oe, m_dir);
      chk("R10", per_a_o & m_dir, m_addr & m_dir);
      case (cfg_addr)
         2'd0: e_rd = {7'b0, m_mode};
         2'd1: e_rd = m_dir[7:0];
         2'd2: e_rd = m_dir[15:8];
         default: e_rd = 8'h00;
      endcase
      chk("R11", cfg_rdata, e_rd);
   endtask

   // inputs are set at a falling edge; compare, then cross one rising edge
   task automatic step();
      #3;
      compare_all();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      psel_n = 2'b11; rd_n = 1; wr_n = 1; cfg_we = 0; addr_le = 0;
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
      cfg_addr = a; cfg_wdata = d; cfg_we = 1;
      step();
      cfg_we = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      @(negedge clk);
      #2;
      // R1: reset state
      chk("R1", {per_d_oe, cpu_d_oe}, 2'b00);
      chk("R1", per_a_oe, 16'h0000);
      for (int a = 0; a < 3; a++) begin
         cfg_addr = a[1:0]; #1;
         chk("R1", cfg_rdata, 8'h00);
      end
      @(negedge clk);
      rst_n = 1;
      idle();
      step();

      // R5: mode off blocks a select + write strobe
      psel_n = 2'b10; wr_n = 0; cpu_d_i = 8'h3C;
      #1 chk("R5", {per_d_oe, cpu_d_oe}, 2'b00);
      step();
      idle();

      // R11: mode write keeps bit 0 only
      cfg_write(2'd0, 8'hFF);
      cfg_addr = 2'd0; #1 chk("R11", cfg_rdata, 8'h01);
      step();

      // R2: write transfer via each select pattern
      foreach (psel_n[i]) ;
      for (int s = 0; s < 3; s++) begin
         psel_n = (s == 0) ? 2'b10 : (s == 1) ? 2'b01 : 2'b00;
         wr_n = 0; rd_n = 1; cpu_d_i = 8'h5A + 8'(s);
         #1 chk("R2", {per_d_oe, per_d_o}, {1'b1, 8'h5A + 8'(s)});
         step();
      end
      // R3: read transfer
      psel_n = 2'b01; wr_n = 1; rd_n = 0; per_d_i = 8'hC3;
      #1 chk("R3", {cpu_d_oe, cpu_d_o}, {1'b1, 8'hC3});
      step();
      // R4: no select
      psel_n = 2'b11;
      #1 chk("R4", {per_d_oe, cpu_d_oe}, 2'b00);
      step();
      // R6 / R7: both strobes together
      psel_n = 2'b00; rd_n = 0; wr_n = 0;
      #1 chk("R6", {per_d_oe, cpu_d_oe}, 2'b00);
      chk("R7", per_d_oe & cpu_d_oe, 1'b0);
      step();
      idle();

      // R10: latch an address, then hold it with a new cpu_addr
      cpu_addr = 16'h1234; addr_le = 1; step();
      addr_le = 0; cpu_addr = 16'hFFFF; step();

      // R9: direction write visible only after the sampling edge
      cfg_addr = 2'd1; cfg_wdata = 8'hA5; cfg_we = 1;
      #1 chk("R9", per_a_oe, 16'h0000);
      step();
      cfg_we = 0;
      chk("R9", per_a_oe, 16'h00A5);
      chk("R10", per_a_o & 16'h00A5, 16'h1234 & 16'h00A5);
      cfg_write(2'd2, 8'h0F);
      chk("R8", per_a_oe, 16'h0FA5);

      // R11: offset 3 writes change nothing
      cfg_write(2'd3, 8'hEE);
      cfg_addr = 2'd3; #1 chk("R11", cfg_rdata, 8'h00);
      cfg_addr = 2'd1; #1 chk("R11", cfg_rdata, 8'hA5);
      cfg_addr = 2'd2; #1 chk("R11", cfg_rdata, 8'h0F);
      step();

      // same-cycle: mode cleared during a live write transfer
      psel_n = 2'b10; wr_n = 0; cpu_d_i = 8'h99;
      cfg_addr = 2'd0; cfg_wdata = 8'h00; cfg_we = 1;
      #1 chk("R2", per_d_oe, 1'b1);
      step();
      cfg_we = 0;
      chk("R5", per_d_oe, 1'b0);
      idle();
      cfg_write(2'd0, 8'h01);

      // random traffic, register writes overlapping transfers
      for (int i = 0; i < 2000; i++) begin
         psel_n   = 2'($urandom);
         rd_n     = 1'($urandom);
         wr_n     = 1'($urandom);
         cpu_d_i  = 8'($urandom);
         per_d_i  = 8'($urandom);
         cpu_addr = 16'($urandom);
         addr_le  = ($urandom % 4) == 0;
         cfg_addr = 2'($urandom);
         cfg_wdata = 8'($urandom);
         cfg_we   = ($urandom % 8) == 0;
         if (cfg_we && cfg_addr == 2'd0) cfg_wdata[0] = ($urandom % 4) != 0;
         step();
      end
      idle();
      step();
      finish_run();
   end
endmodule